// File: doc/BRIEF.md
# Fractional Baud Clock Prescaler

This block sits in front of a UART baud-rate divisor and produces a single-cycle clock-enable strobe, `baud_en`, for it. It runs in one of two modes. In pass-through mode the strobe is high on every input clock, so the divisor sees the full clock rate. In divide mode the input clock is divided by the fractional ratio M + N/8. The ratio is held in an 8-bit ratio register. M is the integer part in bits 7:3 and N is the number of eighths in bits 2:0.

An accumulator in units of one eighth creates the fraction. Each strobe period lasts either M or M+1 input clocks. Every run of eight consecutive periods adds up to exactly 8M + N clocks. After reset the ratio register holds 0x20, which is a divide by 4. The mode-select bit loads the inverse of a clock-select strap input at reset. The host writes the ratio register at any time. It can change the mode-select bit only while the enhanced-mode enable is high. Register changes reach the strobe generator only at a strobe boundary, so no period is ever cut short.

The controller is a three-state machine:
- ST_BYPASS: pass-through mode, strobe on every clock.
- ST_COUNT: divide mode, between strobes.
- ST_EDGE: divide mode, the strobe cycle.

Its transitions are:
- *stay_bypass*: ST_BYPASS or ST_EDGE goes to ST_BYPASS while select is 0.
- *start_long*: ST_BYPASS or ST_EDGE goes to ST_COUNT when select is 1 and the new period is longer than one clock.
- *start_unit*: ST_BYPASS or ST_EDGE goes to ST_EDGE when select is 1 and the new period is one clock.
- *count_down*: ST_COUNT stays in ST_COUNT while more than two clocks remain.
- *count_last*: ST_COUNT goes to ST_EDGE when two clocks remain.

Top module: `baudpre_top`

## Requirements
- R1: While the active mode is pass-through (select bit 0), `baud_en` is high on every clock.
- R2: In divide mode with M ≥ 1, each strobe period is M or M+1 clocks long, and any 8 consecutive periods total exactly 8M + N clocks. M is ratio bits 7:3 and N is ratio bits 2:0.
- R3: The eighths accumulator starts at 0 whenever divide mode is entered from pass-through. At each boundary it adds N. A period is M+1 clocks exactly when that sum reaches 8, and the sum is then kept modulo 8.
- R4: After reset the ratio register is 0x20. If divide mode is selected at reset, the first strobe comes on the 4th clock after reset release, and strobes repeat every 4 clocks after that.
- R5: At reset the select bit takes the inverse of `clk_sel_strap`: strap 0 gives divide mode and strap 1 gives pass-through.
- R6: A write of the select bit (`wr_sel` with `wr_sel_data`) takes effect only when `enh_mode` is 1 in the same cycle. Otherwise the bit keeps its value.
- R7: A ratio with M = 0 behaves as M = 1. For example, 0x04 gives periods of 1 and 2 clocks, and 8 periods take 12 clocks.
- R8: New register values take effect only at a strobe boundary. A ratio write in the middle of a period does not change the length of that period.
- R9: A ratio write (`wr_ratio` with `wr_ratio_data`) always updates the ratio register, whatever `enh_mode` is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel_strap | input | 1 | Static strap; its inverse is the reset value of the select bit |
| enh_mode | input | 1 | Enhanced-mode enable; gates select-bit writes |
| wr_ratio | input | 1 | Ratio register write strobe |
| wr_ratio_data | input | 8 | Ratio value: bits 7:3 integer M, bits 2:0 eighths N |
| wr_sel | input | 1 | Select-bit write strobe |
| wr_sel_data | input | 1 | Select value: 1 divide mode, 0 pass-through |
| baud_en | output | 1 | Clock-enable strobe for the downstream divisor |

## Verification
Some properties are checked on every cycle:
- the select bit and the ratio register change only through an accepted write;
- pass-through mode keeps the strobe high on every clock;
- between strobes the period counter only counts down, so no reload happens mid-period;
- the strobe is never absent for longer than the largest possible period.

Other behaviour depends on exact cycle counts and can only be shown by the bench's scenarios:
- the M/M+1 period pattern and its 8M + N total over eight periods;
- the reset value that follows the strap;
- the treatment of M = 0 as M = 1;
- a mid-period ratio write that leaves the current period untouched.

// File: rtl/baudpre_pkg.sv
package baudpre_pkg;

    typedef enum logic [1:0] {
        ST_BYPASS = 2'd0,
        ST_COUNT  = 2'd1,
        ST_EDGE   = 2'd2
    } pre_state_e;

endpackage

// File: rtl/baudpre_regs.sv
module baudpre_regs #(
    parameter int         RATIO_W   = 8,
    parameter logic [7:0] RST_RATIO = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_sel_strap,
    input  logic               enh_mode,
    input  logic               wr_ratio,
    input  logic [RATIO_W-1:0] wr_ratio_data,
    input  logic               wr_sel,
    input  logic               wr_sel_data,
    output logic [RATIO_W-1:0] ratio_q,
    output logic               sel_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ratio_q <= RATIO_W'(RST_RATIO);
        end else if (wr_ratio) begin
            ratio_q <= wr_ratio_data;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sel_q <= ~clk_sel_strap;
        end else if (wr_sel && enh_mode) begin
            sel_q <= wr_sel_data;
        end
    end

endmodule

// File: rtl/baudpre_phase.sv
module baudpre_phase #(
    parameter int RATIO_W = 8,
    parameter int FRAC_W  = 3,
    localparam int INT_W  = RATIO_W - FRAC_W,
    localparam int CNT_W  = INT_W + 1
) (
    input  logic [RATIO_W-1:0] ratio,
    input  logic [FRAC_W-1:0]  acc_in,
    input  logic               fresh,
    output logic [CNT_W-1:0]   len,
    output logic [FRAC_W-1:0]  acc_out
);

    logic [INT_W-1:0]  m_raw;
    logic [INT_W-1:0]  m_eff;
    logic [FRAC_W-1:0] n_val;
    logic [FRAC_W-1:0] acc_base;
    logic [FRAC_W:0]   sum;

    always_comb begin
        m_raw    = ratio[RATIO_W-1:FRAC_W];
        n_val    = ratio[FRAC_W-1:0];
        m_eff    = (m_raw == '0) ? INT_W'(1) : m_raw;
        acc_base = fresh ? '0 : acc_in;
        sum      = {1'b0, acc_base} + {1'b0, n_val};
        len      = CNT_W'(m_eff) + CNT_W'(sum[FRAC_W]);
        acc_out  = sum[FRAC_W-1:0];
    end

endmodule

// File: rtl/baudpre_fsm.sv
module baudpre_fsm
    import baudpre_pkg::*;
#(
    parameter int FRAC_W  = 3,
    parameter int CNT_W   = 6,
    parameter int RST_LEN = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rst_sel,
    input  logic              sel_q,
    input  logic [CNT_W-1:0]  len,
    input  logic [FRAC_W-1:0] acc_nxt,
    output logic [FRAC_W-1:0] acc_q,
    output logic [CNT_W-1:0]  cnt_q,
    output logic              fresh,
    output logic              baud_en
);

    localparam pre_state_e RST_DIV_ST = (RST_LEN == 1) ? ST_EDGE : ST_COUNT;

    pre_state_e        st_q, st_n;
    logic [CNT_W-1:0]  cnt_n;
    logic [FRAC_W-1:0] acc_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q  <= rst_sel ? RST_DIV_ST : ST_BYPASS;
            cnt_q <= CNT_W'(RST_LEN);
            acc_q <= '0;
        end else begin
            st_q  <= st_n;
            cnt_q <= cnt_n;
            acc_q <= acc_n;
        end
    end

    always_comb begin
        st_n  = st_q;
        cnt_n = cnt_q;
        acc_n = acc_q;
        unique case (st_q)
            ST_BYPASS, ST_EDGE: begin
                if (sel_q) begin
                    cnt_n = len;
                    acc_n = acc_nxt;
                    st_n  = (len == CNT_W'(1)) ? ST_EDGE : ST_COUNT;
                end else begin
                    acc_n = '0;
                    st_n  = ST_BYPASS;
                end
            end
            ST_COUNT: begin
                cnt_n = cnt_q - CNT_W'(1);
                st_n  = (cnt_q == CNT_W'(2)) ? ST_EDGE : ST_COUNT;
            end
            default: begin
                st_n = ST_BYPASS;
            end
        endcase
    end

    always_comb begin
        baud_en = (st_q != ST_COUNT);
        fresh   = (st_q == ST_BYPASS);
    end

endmodule

// File: rtl/baudpre_top.sv
module baudpre_top #(
    parameter int         RATIO_W   = 8,
    parameter int         FRAC_W    = 3,
    parameter logic [7:0] RST_RATIO = 8'h20
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clk_sel_strap,
    input  logic               enh_mode,
    input  logic               wr_ratio,
    input  logic [RATIO_W-1:0] wr_ratio_data,
    input  logic               wr_sel,
    input  logic               wr_sel_data,
    output logic               baud_en
);

    localparam int INT_W   = RATIO_W - FRAC_W;
    localparam int CNT_W   = INT_W + 1;
    localparam int RST_M   = int'(RST_RATIO) >> FRAC_W;
    localparam int RST_LEN = (RST_M == 0) ? 1 : RST_M;

    logic [RATIO_W-1:0] ratio_q;
    logic               sel_q;
    logic [CNT_W-1:0]   len;
    logic [FRAC_W-1:0]  acc_nxt;
    logic [FRAC_W-1:0]  acc_q;
    logic [CNT_W-1:0]   cnt_q;
    logic               fresh;

    baudpre_regs #(
        .RATIO_W  (RATIO_W),
        .RST_RATIO(RST_RATIO)
    ) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_sel_strap(clk_sel_strap),
        .enh_mode     (enh_mode),
        .wr_ratio     (wr_ratio),
        .wr_ratio_data(wr_ratio_data),
        .wr_sel       (wr_sel),
        .wr_sel_data  (wr_sel_data),
        .ratio_q      (ratio_q),
        .sel_q        (sel_q)
    );

    baudpre_phase #(
        .RATIO_W(RATIO_W),
        .FRAC_W (FRAC_W)
    ) u_phase (
        .ratio  (ratio_q),
        .acc_in (acc_q),
        .fresh  (fresh),
        .len    (len),
        .acc_out(acc_nxt)
    );

    baudpre_fsm #(
        .FRAC_W (FRAC_W),
        .CNT_W  (CNT_W),
        .RST_LEN(RST_LEN)
    ) u_fsm (
        .clk    (clk),
        .rst_n  (rst_n),
        .rst_sel(~clk_sel_strap),
        .sel_q  (sel_q),
        .len    (len),
        .acc_nxt(acc_nxt),
        .acc_q  (acc_q),
        .cnt_q  (cnt_q),
        .fresh  (fresh),
        .baud_en(baud_en)
    );

endmodule

// File: rtl/baudpre_chk.sv
module baudpre_chk #(
    parameter int RATIO_W = 8,
    parameter int CNT_W   = 6,
    parameter int MAX_LEN = 32
) (
    input logic               clk,
    input logic               rst_n,
    input logic               enh_mode,
    input logic               wr_sel,
    input logic               wr_ratio,
    input logic               baud_en,
    input logic               sel_q,
    input logic [RATIO_W-1:0] ratio_q,
    input logic [CNT_W-1:0]   cnt_q
);

    int gap;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       gap <= 0;
        else if (baud_en) gap <= 0;
        else              gap <= gap + 1;
    end

    AST_SEL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_sel && enh_mode) |=> $stable(sel_q)); // R6

    AST_RATIO_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_ratio |=> $stable(ratio_q)); // R9

    AST_BYPASS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        (baud_en && !sel_q) |=> baud_en); // R1

    AST_MID_COUNTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        !baud_en |=> (cnt_q + CNT_W'(1) == $past(cnt_q))); // R8

    AST_NO_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        gap < MAX_LEN); // R7

endmodule

bind baudpre_top baudpre_chk #(
    .RATIO_W(RATIO_W),
    .CNT_W  (CNT_W),
    .MAX_LEN(1 << INT_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .enh_mode(enh_mode),
    .wr_sel  (wr_sel),
    .wr_ratio(wr_ratio),
    .baud_en (baud_en),
    .sel_q   (sel_q),
    .ratio_q (ratio_q),
    .cnt_q   (cnt_q)
);

// File: tb/tb_baudpre_top.sv
`timescale 1ns/1ps
module tb_baudpre_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clk_sel_strap = 1'b0;
    logic       enh_mode = 1'b0;
    logic       wr_ratio = 1'b0;
    logic [7:0] wr_ratio_data = 8'h00;
    logic       wr_sel = 1'b0;
    logic       wr_sel_data = 1'b0;
    logic       baud_en;

    int    tests = 0;
    int    fails = 0;
    string cur_req = "R4";
    bit    done = 1'b0;

    always #4 clk = ~clk;

    baudpre_top dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .clk_sel_strap(clk_sel_strap),
        .enh_mode     (enh_mode),
        .wr_ratio     (wr_ratio),
        .wr_ratio_data(wr_ratio_data),
        .wr_sel       (wr_sel),
        .wr_sel_data  (wr_sel_data),
        .baud_en      (baud_en)
    );

    // Behavioural reference: registers plus a "clocks left in period" counter.
    int m_sel, m_ratio, m_div, m_left, m_acc;

    function automatic bit exp_en();
        return (m_div == 0) || (m_left == 1);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_sel   = clk_sel_strap ? 0 : 1;
            m_ratio = 32;
            m_div   = m_sel;
            m_left  = 4;
            m_acc   = 0;
        end else begin
            if (exp_en()) begin
                if (m_sel != 0) begin
                    int mi, ni, a;
                    mi = m_ratio / 8;
                    if (mi == 0) mi = 1;
                    ni = m_ratio % 8;
                    a  = ((m_div != 0) ? m_acc : 0) + ni;
                    m_left = mi + ((a >= 8) ? 1 : 0);
                    m_acc  = a % 8;
                    m_div  = 1;
                end else begin
                    m_div = 0;
                    m_acc = 0;
                end
            end else begin
                m_left = m_left - 1;
            end
            if (wr_ratio) m_ratio = int'(wr_ratio_data);
            if (wr_sel && enh_mode) m_sel = wr_sel_data ? 1 : 0;
        end
    end

    always @(negedge clk) begin
        if (rst_n && !done) begin
            tests++;
            if (baud_en !== exp_en()) begin
                fails++;
                $display("FAIL %s per-cycle strobe: actual %0b expected %0b at %0t",
                         cur_req, baud_en, exp_en(), $time);
            end
        end
    end

    task automatic check(input string req, input int act, input int expv, input string what);
        tests++;
        if (act != expv) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
        end
    endtask

    task automatic do_reset(input bit strap);
        @(negedge clk);
        rst_n = 1'b0;
        clk_sel_strap = strap;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr_r(input logic [7:0] v);
        @(negedge clk);
        wr_ratio = 1'b1;
        wr_ratio_data = v;
        @(negedge clk);
        wr_ratio = 1'b0;
    endtask

    task automatic wr_s(input bit v, input bit enh);
        @(negedge clk);
        wr_sel = 1'b1;
        wr_sel_data = v;
        enh_mode = enh;
        @(negedge clk);
        wr_sel = 1'b0;
        enh_mode = 1'b0;
    endtask

    // Clocks from one strobe until the n-th following strobe.
    task automatic span(input int n, output int cyc);
        int k;
        while (baud_en !== 1'b1) @(negedge clk);
        cyc = 0;
        k = 0;
        while (k < n) begin
            @(negedge clk);
            cyc++;
            if (baud_en === 1'b1) k++;
        end
    endtask

    task automatic count_en(input int n, output int c);
        c = 0;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (baud_en === 1'b1) c++;
        end
    endtask

    initial begin
        int c, t;

        // R5 / R4: strap 0 selects divide mode, ratio 0x20 divides by 4.
        cur_req = "R4";
        do_reset(1'b0);
        c = 0;
        for (int i = 1; i <= 4; i++) begin
            if (baud_en === 1'b1) c = i;
            @(negedge clk);
        end
        check("R4", c, 4, "clock of first strobe after reset");
        count_en(16, c);
        check("R5", c, 4, "strobes in 16 clocks with strap 0");

        // R9 / R2: ratio 0x23 -> 4 + 3/8.
        cur_req = "R2";
        wr_r(8'h23);
        span(2, t);
        span(8, t);
        check("R2", t, 35, "8 periods at ratio 0x23");
        span(1, t);
        check("R3", (t == 4 || t == 5) ? 1 : 0, 1, "single period is M or M+1");

        // R9 with enh_mode low still loads the ratio.
        cur_req = "R9";
        wr_r(8'h17);
        span(2, t);
        span(8, t);
        check("R9", t, 23, "8 periods at ratio 0x17");

        // R7: M = 0 behaves as 1.
        cur_req = "R7";
        wr_r(8'h04);
        span(2, t);
        span(8, t);
        check("R7", t, 12, "8 periods at ratio 0x04");
        wr_r(8'h00);
        span(2, t);
        span(4, t);
        check("R7", t, 4, "ratio 0x00 strobes every clock");

        // R6: select write without enhanced mode is ignored.
        cur_req = "R6";
        wr_r(8'h18);
        wr_s(1'b0, 1'b0);
        span(1, t);
        count_en(30, c);
        check("R6", c, 10, "strobes in 30 clocks after ignored select write");

        // R1: accepted select write to pass-through.
        cur_req = "R1";
        wr_s(1'b0, 1'b1);
        span(1, t);
        count_en(12, c);
        check("R1", c, 12, "pass-through strobes in 12 clocks");

        // R3: re-entering divide mode starts the accumulator at 0 (ratio 0x14: 2,3,2,3...).
        cur_req = "R3";
        wr_r(8'h14);
        wr_s(1'b1, 1'b1);
        span(1, t);
        check("R3", t, 2, "first period after entering divide mode");
        span(1, t);
        check("R3", t, 3, "second period carries");

        // R8: mid-period ratio write does not shorten the running period.
        cur_req = "R8";
        wr_r(8'hF8);
        span(2, t);
        while (baud_en !== 1'b1) @(negedge clk);
        t = 0;
        repeat (3) begin @(negedge clk); t++; end
        wr_ratio = 1'b1;
        wr_ratio_data = 8'h08;
        @(negedge clk);
        t++;
        wr_ratio = 1'b0;
        while (baud_en !== 1'b1) begin @(negedge clk); t++; end
        check("R8", t, 31, "period spanning a ratio write");
        span(1, t);
        check("R8", t, 1, "period after boundary uses new ratio");

        // R5: strap 1 selects pass-through at reset.
        cur_req = "R5";
        do_reset(1'b1);
        count_en(10, c);
        check("R5", c, 10, "strobes in 10 clocks with strap 1");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        done = 1'b1;
        tests++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule